// File: doc/BRIEF.md
# Two-phase watchdog timer

This block is a watchdog timer whose timeout runs in two phases, one after the other. The bus clock feeds a free-running power-of-two prescaler, and every phase counts prescaled ticks. While the first phase runs, software can kick the timer, which restarts both the phase count and the prescaler. When the first phase runs out, a sticky pretimeout status bit is set and the second phase begins. Kicks have no effect in the second phase. When the second phase runs out, a sticky timeout status bit is set. In the same cycle, a one-cycle reset request pulse goes out on one of three lines. The reset mode chooses which line: the whole chip, the processor with its crypto engine, or a software-only restart. After the pulse the timer drops its enable and goes idle. Clearing the enable in either phase is the only way to avoid the reset.

Three word-wide registers, each written in a single cycle, control the block. They hold the controls, a kick strobe, and the status. Reads are combinational. Each phase length is stored as the tick count minus one, so every phase lasts at least one tick. With the default prescaler of 2^28, a tick is about 1.34 s at 200 MHz, and the 32-tick maximum is about 43 s.

Top module: `twophase_wdt`

## Requirements
- R1: After reset, every register field reads 0, the reported phase is idle (0), and the two interrupt lines and three reset lines are low.
- R2: A write of 1 to the enable bit CTRL[0] (address 0) starts phase one on the next clock edge and restarts the prescaler. A tick then lands every 2^PRE_W cycles, and phase one ends on tick CTRL[12:8]+1.
- R3: When phase one ends, pretimeout status STAT[0] (address 2) is set and phase two begins on the same edge. irq_pretimeout equals STAT[0] AND mask CTRL[3]. STAT[5:4] reports the phase as 0 idle, 1 phase one, 2 phase two.
- R4: A write to address 1 with bit 0 set is a kick. During phase one it clears the phase count and the prescaler. If it lands on the edge of the final phase-one tick, the kick wins and no pretimeout occurs.
- R5: A kick during phase two changes neither the phase, nor the count, nor the cycle in which the reset comes.
- R6: Phase two ends on tick CTRL[20:16]+1. On that edge the enable clears and the block goes idle. For the next cycle only, the selected reset line and timeout status STAT[1] are high. irq_timeout equals STAT[1] AND mask CTRL[4].
- R7: Reset mode CTRL[2:1] selects the reset line: 0 gives rst_req_cpu, 1 gives rst_req_chip, 2 gives rst_req_soft, and 3 gives rst_req_cpu.
- R8: Writing a 1 to a bit of STAT clears that status bit. Writing 0 leaves it unchanged.
- R9: Clearing CTRL[0] in either phase returns the block to idle with both counts cleared, and no reset follows. A later enable starts a full first phase.
- R10: A length field of 0 gives one tick, and a length field of 31 gives 32 ticks.
- R11: At most one reset line is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 control, 1 kick, 2 status |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| irq_pretimeout | output | 1 | Masked pretimeout status |
| irq_timeout | output | 1 | Masked timeout status |
| rst_req_chip | output | 1 | Whole-chip reset request pulse |
| rst_req_cpu | output | 1 | Processor and crypto engine reset request pulse |
| rst_req_soft | output | 1 | Software-only restart request pulse |

## Verification
Two events can fall on the same edge: a kick and the tick that ends a phase. The bench places the kick write so that it is captured on exactly the edge where the final phase-one tick lands. In that case the pretimeout must move a full first phase later. It places another kick on the edge where phase two expires, and there the reset must still fire on time. A scoreboard holds the expected cycle of every pretimeout rise and every reset pulse. Any event that comes early, comes late, goes to the wrong line or was not expected counts as an error.

// File: rtl/twp_wdt_pkg.sv
package twp_wdt_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ONE  = 2'd1,
      PH_TWO  = 2'd2
   } phase_e;

   localparam int NUM_RST  = 3;
   localparam int LINE_CPU  = 0;
   localparam int LINE_CHIP = 1;
   localparam int LINE_SOFT = 2;

   localparam int A_CTRL = 0;
   localparam int A_KICK = 1;
   localparam int A_STAT = 2;

   // mode code -> one-hot reset line select; unused code falls back to cpu
   function automatic logic [NUM_RST-1:0] mode_to_line(input logic [1:0] mode);
      logic [NUM_RST-1:0] sel;
      sel = '0;
      case (mode)
         2'd1:    sel[LINE_CHIP] = 1'b1;
         2'd2:    sel[LINE_SOFT] = 1'b1;
         default: sel[LINE_CPU]  = 1'b1;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/twp_wdt_regs.sv
module twp_wdt_regs
   import twp_wdt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  phase_e            phase,
   input  logic              pre_evt,
   input  logic              tmo_evt,
   output logic              en,
   output logic [1:0]        mode,
   output logic              mask_pre,
   output logic              mask_tmo,
   output logic [LEN_W-1:0]  len1,
   output logic [LEN_W-1:0]  len2,
   output logic              kick,
   output logic              sts_pre,
   output logic              sts_tmo
);

   localparam int B_EN   = 0;
   localparam int B_MODE = 1;
   localparam int B_MPRE = 3;
   localparam int B_MTMO = 4;
   localparam int B_L1   = 8;
   localparam int B_L2   = 16;
   localparam int B_PH   = 4;

   generate
      if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
         $error("twp_wdt_regs: LEN_W must lie in 1..8");
      end
      if (DATA_W < B_L2 + LEN_W) begin : g_bad_data
         $error("twp_wdt_regs: DATA_W too narrow for the control fields");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("twp_wdt_regs: ADDR_W must be at least 2");
      end
   endgenerate

   logic wr_ctrl, wr_stat;
   logic en_q, mpre_q, mtmo_q, spre_q, stmo_q;
   logic [1:0] mode_q;
   logic [LEN_W-1:0] len1_q, len2_q;
   logic unused_wdata;

   assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign wr_stat = wr_en && (wr_addr == ADDR_W'(A_STAT));
   assign kick    = wr_en && (wr_addr == ADDR_W'(A_KICK)) && wr_data[0];
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= 2'd0;
         mpre_q <= 1'b0;
         mtmo_q <= 1'b0;
         len1_q <= '0;
         len2_q <= '0;
      end else if (wr_ctrl) begin
         en_q   <= wr_data[B_EN];
         mode_q <= wr_data[B_MODE +: 2];
         mpre_q <= wr_data[B_MPRE];
         mtmo_q <= wr_data[B_MTMO];
         len1_q <= wr_data[B_L1 +: LEN_W];
         len2_q <= wr_data[B_L2 +: LEN_W];
      end else if (tmo_evt) begin
         en_q   <= 1'b0;
      end
   end

   // sticky status: a new event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spre_q <= 1'b0;
         stmo_q <= 1'b0;
      end else begin
         spre_q <= pre_evt | (spre_q & ~(wr_stat & wr_data[0]));
         stmo_q <= tmo_evt | (stmo_q & ~(wr_stat & wr_data[1]));
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(A_CTRL)) begin
         rd_data[B_EN]          = en_q;
         rd_data[B_MODE +: 2]   = mode_q;
         rd_data[B_MPRE]        = mpre_q;
         rd_data[B_MTMO]        = mtmo_q;
         rd_data[B_L1 +: LEN_W] = len1_q;
         rd_data[B_L2 +: LEN_W] = len2_q;
      end else if (rd_addr == ADDR_W'(A_STAT)) begin
         rd_data[0]         = spre_q;
         rd_data[1]         = stmo_q;
         rd_data[B_PH +: 2] = phase;
      end
   end

   assign en       = en_q;
   assign mode     = mode_q;
   assign mask_pre = mpre_q;
   assign mask_tmo = mtmo_q;
   assign len1     = len1_q;
   assign len2     = len2_q;
   assign sts_pre  = spre_q;
   assign sts_tmo  = stmo_q;

endmodule

// File: rtl/twp_wdt_presc.sv
module twp_wdt_presc #(
   parameter int PRE_W = 28
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);

   generate
      if (PRE_W < 1 || PRE_W > 48) begin : g_bad_pre
         $error("twp_wdt_presc: PRE_W must lie in 1..48");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || restart)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && !restart && (&cnt_q);

endmodule

// File: rtl/twp_wdt_core.sv
module twp_wdt_core
   import twp_wdt_pkg::*;
#(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             kick,
   input  logic             tick,
   input  logic [LEN_W-1:0] len1,
   input  logic [LEN_W-1:0] len2,
   output phase_e           phase,
   output logic [LEN_W-1:0] cnt,
   output logic             run,
   output logic             restart,
   output logic             pre_evt,
   output logic             tmo_evt
);

   phase_e           ph_q, ph_d;
   logic [LEN_W-1:0] cnt_q, cnt_d;
   logic             last1, last2;

   assign last1 = (cnt_q == len1);
   assign last2 = (cnt_q == len2);

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      if (!en) begin
         ph_d  = PH_IDLE;
         cnt_d = '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               ph_d  = PH_ONE;
               cnt_d = '0;
            end
            PH_ONE: begin
               if (kick) begin
                  cnt_d = '0;
               end else if (tick) begin
                  if (last1) begin
                     ph_d  = PH_TWO;
                     cnt_d = '0;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end
            end
            PH_TWO: begin
               if (tick) begin
                  if (last2) begin
                     ph_d  = PH_IDLE;
                     cnt_d = '0;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
      end
   end

   assign run     = (ph_q != PH_IDLE);
   assign restart = en && ((ph_q == PH_IDLE) || ((ph_q == PH_ONE) && kick));
   assign pre_evt = en && (ph_q == PH_ONE) && !kick && tick && last1;
   assign tmo_evt = en && (ph_q == PH_TWO) && tick && last2;
   assign phase   = ph_q;
   assign cnt     = cnt_q;

endmodule

// File: rtl/twp_wdt_rstout.sv
module twp_wdt_rstout
   import twp_wdt_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [1:0]         mode,
   output logic [NUM_RST-1:0] lines
);

   logic [NUM_RST-1:0] sel;

   assign sel = mode_to_line(mode);

   generate
      for (genvar g = 0; g < NUM_RST; g++) begin : g_line
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pulse_q <= 1'b0;
            else
               pulse_q <= fire & sel[g];
         end
         assign lines[g] = pulse_q;
      end
   endgenerate

endmodule

// File: rtl/twophase_wdt.sv
module twophase_wdt
   import twp_wdt_pkg::*;
#(
   parameter int PRE_W  = 28,
   parameter int LEN_W  = 5,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_pretimeout,
   output logic              irq_timeout,
   output logic              rst_req_chip,
   output logic              rst_req_cpu,
   output logic              rst_req_soft
);

   logic               en_w, kick_w, tick_w, run_w, restart_w;
   logic               pre_evt_w, tmo_evt_w, sts_pre_w, sts_tmo_w;
   logic               mpre_w, mtmo_w;
   logic [1:0]         mode_w;
   logic [LEN_W-1:0]   len1_w, len2_w, cnt_w;
   phase_e             phase_w;
   logic [NUM_RST-1:0] rst_lines_w;

   twp_wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .phase    (phase_w),
      .pre_evt  (pre_evt_w),
      .tmo_evt  (tmo_evt_w),
      .en       (en_w),
      .mode     (mode_w),
      .mask_pre (mpre_w),
      .mask_tmo (mtmo_w),
      .len1     (len1_w),
      .len2     (len2_w),
      .kick     (kick_w),
      .sts_pre  (sts_pre_w),
      .sts_tmo  (sts_tmo_w)
   );

   twp_wdt_presc #(.PRE_W(PRE_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_w),
      .restart (restart_w),
      .tick    (tick_w)
   );

   twp_wdt_core #(.LEN_W(LEN_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_w),
      .kick    (kick_w),
      .tick    (tick_w),
      .len1    (len1_w),
      .len2    (len2_w),
      .phase   (phase_w),
      .cnt     (cnt_w),
      .run     (run_w),
      .restart (restart_w),
      .pre_evt (pre_evt_w),
      .tmo_evt (tmo_evt_w)
   );

   twp_wdt_rstout u_rstout (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (tmo_evt_w),
      .mode  (mode_w),
      .lines (rst_lines_w)
   );

   assign irq_pretimeout = sts_pre_w & mpre_w;
   assign irq_timeout    = sts_tmo_w & mtmo_w;
   assign rst_req_cpu    = rst_lines_w[LINE_CPU];
   assign rst_req_chip   = rst_lines_w[LINE_CHIP];
   assign rst_req_soft   = rst_lines_w[LINE_SOFT];

endmodule

// File: rtl/twophase_wdt_chk.sv
module twophase_wdt_chk #(
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             kick,
   input logic             tick,
   input logic [1:0]       phase,
   input logic [LEN_W-1:0] cnt,
   input logic             sts_tmo,
   input logic [2:0]       lines
);

   localparam logic [1:0] P_IDLE = 2'd0;
   localparam logic [1:0] P_ONE  = 2'd1;
   localparam logic [1:0] P_TWO  = 2'd2;

   logic any_rst;
   assign any_rst = |lines;

   AST_START_PHASE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_IDLE && en) |=> (phase == P_ONE && cnt == '0)); // R2

   AST_TWO_FOLLOWS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_TWO && $past(phase) != P_TWO) |-> $past(phase) == P_ONE); // R3

   AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_ONE && en && kick) |=> (phase == P_ONE && cnt == '0)); // R4

   AST_KICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_TWO && en && kick && !tick) |=> (phase == P_TWO && $stable(cnt))); // R5

   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      any_rst |=> !any_rst); // R6

   AST_RST_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      any_rst |-> ($past(phase) == P_TWO && phase == P_IDLE && !en && sts_tmo)); // R6

   AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> phase == P_IDLE); // R9

   AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lines)); // R11

endmodule

bind twophase_wdt twophase_wdt_chk #(.LEN_W(LEN_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en_w),
   .kick    (kick_w),
   .tick    (tick_w),
   .phase   (phase_w),
   .cnt     (cnt_w),
   .sts_tmo (sts_tmo_w),
   .lines   (rst_lines_w)
);

// File: tb/twophase_wdt_tb.sv
module twophase_wdt_tb;

   localparam int PW = 3;
   localparam int T  = 1 << PW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = 2'd0;
   logic [31:0] rd_data;
   logic        irq_pretimeout, irq_timeout;
   logic        rst_req_chip, rst_req_cpu, rst_req_soft;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_err = 0;
   int    n_pre = 0;
   int    n_rst = 0;
   bit    pre_prev = 1'b0;
   string tag = "R1";

   typedef struct packed {
      int       kind;   // 0 pretimeout rise, 1 reset pulse
      int       at;
      logic [2:0] lines; // {soft, chip, cpu}
      logic     tmo;
   } exp_t;

   exp_t sb[$];

   twophase_wdt #(.PRE_W(PW)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .wr_addr        (wr_addr),
      .wr_data        (wr_data),
      .rd_addr        (rd_addr),
      .rd_data        (rd_data),
      .irq_pretimeout (irq_pretimeout),
      .irq_timeout    (irq_timeout),
      .rst_req_chip   (rst_req_chip),
      .rst_req_cpu    (rst_req_cpu),
      .rst_req_soft   (rst_req_soft)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic finish_up();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // ---------------- monitor ----------------
   task automatic got(input int kind, input logic [2:0] lines, input logic tmo);
      exp_t e;
      if (sb.size() == 0) begin
         chk(1'b0, "unexpected event kind", kind, -1);
         return;
      end
      e = sb.pop_front();
      chk(e.kind == kind, "event kind", kind, e.kind);
      chk(e.at == cyc, "event cycle", cyc, e.at);
      if (kind == 1) begin
         chk(lines == e.lines, "reset line", lines, e.lines);
         chk(tmo == e.tmo, "timeout irq with reset", tmo, e.tmo);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_pretimeout && !pre_prev) begin
            n_pre++;
            got(0, 3'b000, 1'b0);
         end
         if (rst_req_cpu | rst_req_chip | rst_req_soft) begin
            n_rst++;
            got(1, {rst_req_soft, rst_req_chip, rst_req_cpu}, irq_timeout);
         end
         pre_prev = irq_pretimeout;
      end
   end

   // ---------------- driver ----------------
   task automatic push(input int kind, input int at, input logic [2:0] lines, input logic tmo);
      exp_t e;
      e.kind = kind; e.at = at; e.lines = lines; e.tmo = tmo;
      sb.push_back(e);
   endtask

   task automatic wr(input int addr, input logic [31:0] data, output int edge_no);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data;
      edge_no = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      @(negedge clk);
      rd_addr = addr[1:0];
      #1;
      data = rd_data;
   endtask

   task automatic kick_at(input int edge_no);
      chk(cyc < edge_no, "kick scheduled in the past", cyc, edge_no - 1);
      while (cyc < edge_no - 1) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic wait_to(input int edge_no);
      while (cyc < edge_no) @(negedge clk);
   endtask

   function automatic logic [31:0] ctrl(input int en, input int mode, input int mp,
                                        input int mt, input int l1, input int l2);
      return 32'(en) | (32'(mode) << 1) | (32'(mp) << 3) | (32'(mt) << 4)
             | (32'(l1) << 8) | (32'(l2) << 16);
   endfunction

   task automatic start(input int mode, input int mp, input int mt,
                        input int l1, input int l2, output int e1);
      int e0;
      wr(2, 32'h3, e0);
      wr(0, ctrl(1, mode, mp, mt, l1, l2), e0);
      e1 = e0 + 1;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual run still going, expected completion");
      finish_up();
   end

   initial begin : main
      logic [31:0] d;
      int e1, k, x, ed, pre_before, rst_before;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // ---- reset state
      tag = "R1";
      rd(0, d); chk(d == 0, "CTRL after reset", d, 0);
      rd(2, d); chk(d == 0, "STAT after reset", d, 0);
      chk({irq_pretimeout, irq_timeout, rst_req_chip, rst_req_cpu, rst_req_soft} == 0,
          "outputs after reset", {irq_pretimeout, irq_timeout, rst_req_chip, rst_req_cpu, rst_req_soft}, 0);

      // ---- basic minimum run, cpu mode
      tag = "R2 R3 R6 R10";
      start(0, 1, 1, 0, 0, e1);
      push(0, e1 + T, 3'b000, 1'b0);
      push(1, e1 + 2 * T, 3'b001, 1'b1);
      rd(2, d); chk(d[5:4] == 2'd1, "phase one after enable", d[5:4], 1);
      wait_to(e1 + 2 * T + 3);
      rd(0, d); chk(d[0] == 1'b0, "enable cleared after reset pulse", d[0], 0);
      rd(2, d); chk(d[5:0] == 6'h03, "idle with both status bits", d[5:0], 3);

      // ---- write-one-to-clear
      tag = "R8";
      wr(2, 32'h0, ed); rd(2, d); chk(d[1:0] == 2'b11, "write 0 keeps status", d[1:0], 3);
      wr(2, 32'h1, ed); rd(2, d); chk(d[1:0] == 2'b10, "clear pretimeout only", d[1:0], 2);
      chk(irq_pretimeout == 1'b0, "pretimeout irq after clear", irq_pretimeout, 0);
      wr(2, 32'h2, ed); rd(2, d); chk(d[1:0] == 2'b00, "clear timeout", d[1:0], 0);
      chk(irq_timeout == 1'b0, "timeout irq after clear", irq_timeout, 0);

      // ---- kicks in phase one, chip mode
      tag = "R4";
      start(1, 1, 1, 2, 1, e1);
      kick_at(e1 + 10);
      rd(2, d); chk(d[5:4] == 2'd1, "still phase one after kick", d[5:4], 1);
      k = e1 + 25;
      push(0, k + 3 * T, 3'b000, 1'b0);
      push(1, k + 5 * T, 3'b010, 1'b1);
      kick_at(k);
      wait_to(k + 5 * T + 3);
      chk(sb.size() == 0, "kick run drained", sb.size(), 0);

      // ---- kick on the final phase-one tick, software mode
      tag = "R4";
      start(2, 1, 1, 1, 0, e1);
      x = e1 + 2 * T;
      push(0, x + 2 * T, 3'b000, 1'b0);
      push(1, x + 3 * T, 3'b100, 1'b1);
      kick_at(x);
      wait_to(x + 3 * T + 3);
      chk(sb.size() == 0, "tick/kick collision drained", sb.size(), 0);

      // ---- kicks in phase two are ignored
      tag = "R5";
      start(0, 1, 1, 0, 2, e1);
      push(0, e1 + T, 3'b000, 1'b0);
      push(1, e1 + 4 * T, 3'b001, 1'b1);
      kick_at(e1 + T + 4);
      rd(2, d); chk(d[5:4] == 2'd2, "phase two after kick", d[5:4], 2);
      kick_at(e1 + 3 * T);
      kick_at(e1 + 4 * T);
      wait_to(e1 + 4 * T + 3);
      chk(sb.size() == 0, "phase two kicks drained", sb.size(), 0);

      // ---- disable during phase two, then a fresh start
      tag = "R9";
      start(0, 1, 1, 0, 1, e1);
      push(0, e1 + T, 3'b000, 1'b0);
      wait_to(e1 + T + 4);
      rst_before = n_rst;
      wr(0, ctrl(0, 0, 1, 1, 0, 1), ed);
      wait_to(e1 + 6 * T);
      chk(n_rst == rst_before, "no reset after disable", n_rst, rst_before);
      rd(2, d); chk(d[5:4] == 2'd0, "idle after disable", d[5:4], 0);
      start(0, 1, 1, 0, 1, e1);
      push(0, e1 + T, 3'b000, 1'b0);
      push(1, e1 + 3 * T, 3'b001, 1'b1);
      wait_to(e1 + 3 * T + 3);
      chk(sb.size() == 0, "restart after disable drained", sb.size(), 0);

      // ---- longest phases, reserved mode code
      tag = "R7 R10";
      start(3, 1, 1, 31, 31, e1);
      push(0, e1 + 32 * T, 3'b000, 1'b0);
      push(1, e1 + 64 * T, 3'b001, 1'b1);
      wait_to(e1 + 64 * T + 3);
      chk(sb.size() == 0, "maximum run drained", sb.size(), 0);

      // ---- masks off
      tag = "R3 R6";
      pre_before = n_pre;
      start(1, 0, 0, 0, 0, e1);
      push(1, e1 + 2 * T, 3'b010, 1'b0);
      wait_to(e1 + 2 * T + 3);
      chk(n_pre == pre_before, "masked pretimeout stays low", n_pre, pre_before);
      rd(2, d); chk(d[1:0] == 2'b11, "status set while masked", d[1:0], 3);

      tag = "R11";
      chk(sb.size() == 0, "scoreboard empty at end", sb.size(), 0);
      finish_up();
   end

endmodule